// File: doc/BRIEF.md
# Dual-Mode Frequency and Period Counter

This block measures one of two digital input signals, a fast one and a slow one, with a saturating counter. In frequency mode it counts rising edges of the chosen input during a gate window that is timed with a reference tick enable. In period mode it counts reference ticks across a chosen number of cycles of the slow input. A two-bit mode code and a two-bit gate code are held in a small configuration register. That register is written while no measurement is running. A start pulse then begins a measurement with those settings.

Software, or a sequencer, writes the configuration and pulses `start`. It waits for `done` and reads `count`. The `overflow` flag tells it whether the value is trustworthy. Both inputs pass through synchronizer flops before their rising edges are detected, so they may be asynchronous to `clk`. The first gate boundary of a frequency measurement is aligned to a reference tick.

Top module: `freq_period_counter`

## Requirements
- R1: After reset `count` is 0, `done` is 0 and `overflow` is 0. The configuration holds mode 00 and gate code 00, so a start with no configuration write gives a fast-input frequency measurement over 1 ms.
- R2: A cycle with `cfg_we` high loads `cfg_mode` and `cfg_gate` only when no measurement is armed or running. A write during a measurement is ignored, both for that measurement and for later ones.
- R3: On the cycle after `start` is sampled high, `count` is 0, `done` is 0 and `overflow` is 0, even if a measurement was already in progress. That measurement is abandoned.
- R4: With mode 00 (fast-input frequency), the window opens at the first `ref_tick` after start and closes at the N-th following `ref_tick`. `count` is the number of rising edges of `hf_in` within the window. Falling edges are not counted.
- R5: With mode 01 (slow-input frequency), the same window applies to rising edges of `lf_in`. `hf_in` has no effect.
- R6: Gate code 0, 1, 2 and 3 selects 1, 4, 8 and 16 ms. In frequency mode the window lasts that number of milliseconds times TICKS_PER_MS reference ticks.
- R7: With mode 10 (slow-input period), the measurement arms on a rising edge of `lf_in`. `count` is then the number of `ref_tick` pulses up to the rising edge that completes N cycles, where N is 1, 4, 8 or 16 for gate code 0 to 3. Mode 11 behaves exactly as mode 10.
- R8: `done` rises when a measurement finishes. It then stays high, with `count` unchanged, until the next start.
- R9: `count` stops at all ones instead of wrapping. An increment requested while it is at all ones sets `overflow`.
- R10: In period mode, if the measurement has not finished within TIMEOUT_MS times TICKS_PER_MS reference ticks of the start, it ends. `done` and `overflow` are both set, and `count` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle reference time-base enable |
| hf_in | input | 1 | Fast signal to measure (asynchronous) |
| lf_in | input | 1 | Slow signal to measure (asynchronous) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode code: 00 fast freq, 01 slow freq, 10/11 slow period |
| cfg_gate | input | 2 | Gate code: 1/4/8/16 ms or 1/4/8/16 cycles |
| start | input | 1 | Clear and begin a measurement |
| count | output | CNT_W | Measured value |
| done | output | 1 | Measurement complete |
| overflow | output | 1 | Saturation or period timeout occurred |

## Verification
Each vector drives the fast and slow inputs at different periods. A count taken from the wrong input, or one that includes falling edges, would therefore be off by a clear factor. The reference tick period is chosen to divide every window exactly. The expected results then follow from the gate length alone and do not depend on synchronizer latency or phase. Frequency vectors sweep all four gate codes. Period vectors use tick rates of one and two clocks, which separates the tick count from the cycle count. Directed cases cover a slow input held low until timeout, saturation on a narrow-counter instance, a configuration write during a run, and a restart.

// File: rtl/fpc_pkg.sv
// Shared types and helpers for the frequency/period counter.
// Assumes the gate code is two bits wide.
package fpc_pkg;

    typedef enum logic [1:0] {
        MODE_HF_FREQ   = 2'b00,
        MODE_LF_FREQ   = 2'b01,
        MODE_LF_PERIOD = 2'b10,
        MODE_LF_PER_B  = 2'b11
    } meas_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ARM  = 2'b01,
        ST_RUN  = 2'b10
    } meas_state_t;

    // Map a gate code to its multiplier: milliseconds or input cycles.
    function automatic logic [4:0] gate_scale(input logic [1:0] sel);
        case (sel)
            2'd0:    gate_scale = 5'd1;
            2'd1:    gate_scale = 5'd4;
            2'd2:    gate_scale = 5'd8;
            default: gate_scale = 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/fpc_edge_det.sv
// Synchronizes an asynchronous input through STAGES flops and flags
// each rising edge with a one-cycle pulse. Assumes STAGES >= 2.
module fpc_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the input through the synchronizer and keep the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/fpc_sat_count.sv
// Saturating up-counter with a synchronous clear. Clear wins over
// increment. The counter holds at all ones.
module fpc_sat_count #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         at_max
);
    // Count up on inc and stop at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)                 value <= '0;
        else if (clr)               value <= '0;
        else if (inc && !at_max)    value <= value + W'(1);
    end

    assign at_max = &value;
endmodule

// File: rtl/fpc_window.sv
// Event counter that reports the event which completes `limit` events.
// Assumes limit >= 1. It is held at zero while clr is high.
module fpc_window #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ev,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt_q;

    // Count events since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (ev)     cnt_q <= cnt_q + W'(1);
    end

    assign last = ev && !clr && (cnt_q == limit - W'(1));
endmodule

// File: rtl/freq_period_counter.sv
// Frequency or period measurement of one of two inputs.
// Frequency mode: counts input rising edges over a window of reference
// ticks. Period mode: counts reference ticks over N slow-input cycles.
// Assumes ref_tick is a one-cycle enable and that the inputs are slower
// than clk/2 after synchronization.
module freq_period_counter #(
    parameter int CNT_W        = 20,
    parameter int TICKS_PER_MS = 1000,
    parameter int TIMEOUT_MS   = 64,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             hf_in,
    input  logic             lf_in,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_mode,
    input  logic [1:0]       cfg_gate,
    input  logic             start,
    output logic [CNT_W-1:0] count,
    output logic             done,
    output logic             overflow
);
    import fpc_pkg::*;

    localparam int WIN_MAX  = 16 * TICKS_PER_MS;
    localparam int WIN_W    = $clog2(WIN_MAX + 1);
    localparam int TO_LIMIT = TIMEOUT_MS * TICKS_PER_MS;
    localparam int TO_W     = $clog2(TO_LIMIT + 1);

    meas_mode_t  mode_q;
    logic [1:0]  gate_q;
    meas_state_t state_q;
    logic        done_q, ovf_q;

    logic [1:0]       in_vec, rise_vec;
    logic             sel_rise, is_period, arm_go;
    logic             cnt_inc, cnt_max;
    logic             win_ev, win_last, to_ev, to_last;
    logic [WIN_W-1:0] win_limit;
    logic [4:0]       scale;

    // Configuration register, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_HF_FREQ;
            gate_q <= 2'd0;
        end else if (cfg_we && state_q == ST_IDLE) begin
            mode_q <= meas_mode_t'(cfg_mode);
            gate_q <= cfg_gate;
        end
    end

    assign in_vec = {lf_in, hf_in};

    // One synchronizer and edge detector per input.
    for (genvar i = 0; i < 2; i++) begin : g_in
        fpc_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (in_vec[i]),
            .rise (rise_vec[i])
        );
    end

    assign sel_rise  = (mode_q == MODE_HF_FREQ) ? rise_vec[0] : rise_vec[1];
    assign is_period = mode_q[1];
    assign scale     = gate_scale(gate_q);
    assign win_limit = is_period ? WIN_W'(scale)
                                 : WIN_W'(int'(scale) * TICKS_PER_MS);
    assign arm_go    = is_period ? sel_rise : ref_tick;
    assign win_ev    = is_period ? sel_rise : ref_tick;
    assign cnt_inc   = (state_q == ST_RUN) && (is_period ? ref_tick : sel_rise);
    assign to_ev     = ref_tick && is_period && (state_q != ST_IDLE);

    fpc_window #(.W(WIN_W)) u_win (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_q != ST_RUN),
        .ev   (win_ev),
        .limit(win_limit),
        .last (win_last)
    );

    fpc_window #(.W(TO_W)) u_timeout (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (start),
        .ev   (to_ev),
        .limit(TO_W'(TO_LIMIT)),
        .last (to_last)
    );

    fpc_sat_count #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .inc   (cnt_inc),
        .value (count),
        .at_max(cnt_max)
    );

    // Measurement sequencer: arm, run, finish, flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            ovf_q   <= 1'b0;
        end else if (start) begin
            state_q <= ST_ARM;
            done_q  <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            if (cnt_inc && cnt_max) ovf_q <= 1'b1;
            case (state_q)
                ST_ARM: begin
                    if (to_last) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        ovf_q   <= 1'b1;
                    end else if (arm_go) begin
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (win_last) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else if (to_last) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        ovf_q   <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign done     = done_q;
    assign overflow = ovf_q;
endmodule

// File: rtl/fpc_checker.sv
// Temporal checks on the counter's ports. Attached by bind below.
module fpc_checker #(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] count,
    input logic             done,
    input logic             overflow
);
    // R3
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count == '0 && !done && !overflow));

    // R8
    done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R8
    count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(count));

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (count >= $past(count)));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (done || (&count)));
endmodule

bind freq_period_counter fpc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .count   (count),
    .done    (done),
    .overflow(overflow)
);

// File: tb/sim_freq_period_counter.sv
module sim_freq_period_counter;
    localparam int CLK_PERIOD = 10;
    localparam int TPM        = 4;
    localparam int TO_MS      = 64;

    typedef struct packed {
        logic [1:0] mode;
        logic [1:0] gate;
        int         tdiv;
        int         hhalf;
        int         lhalf;
        int         exp_cnt;
    } vec_t;

    // Windows are exact multiples of the tick and input periods.
    localparam vec_t VECS [9] = '{
        '{2'd0, 2'd0, 8, 2, 8, 8},
        '{2'd0, 2'd2, 8, 2, 8, 64},
        '{2'd0, 2'd1, 8, 4, 2, 16},
        '{2'd1, 2'd1, 8, 2, 4, 16},
        '{2'd1, 2'd3, 8, 2, 8, 32},
        '{2'd2, 2'd0, 1, 2, 8, 16},
        '{2'd2, 2'd1, 2, 2, 8, 32},
        '{2'd2, 2'd3, 1, 4, 4, 128},
        '{2'd3, 2'd0, 1, 2, 8, 16}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0, hf_in = 1'b0, lf_in = 1'b0;
    logic        cfg_we = 1'b0, start = 1'b0;
    logic [1:0]  cfg_mode = 2'd0, cfg_gate = 2'd0;
    logic [19:0] count;
    logic        done, overflow;
    logic [5:0]  count_n;
    logic        done_n, overflow_n;

    int checks = 0, fails = 0;
    int tdiv = 8, hhalf = 2, lhalf = 8;
    int tc = 0, hc = 0, lc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    freq_period_counter #(.TICKS_PER_MS(TPM), .TIMEOUT_MS(TO_MS)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .hf_in(hf_in),
        .lf_in(lf_in), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_gate(cfg_gate), .start(start), .count(count), .done(done),
        .overflow(overflow));

    freq_period_counter #(.CNT_W(6), .TICKS_PER_MS(TPM), .TIMEOUT_MS(TO_MS)) u1 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .hf_in(hf_in),
        .lf_in(lf_in), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_gate(cfg_gate), .start(start), .count(count_n), .done(done_n),
        .overflow(overflow_n));

    // Stimulus generator: periodic tick and two square waves, on falling edges.
    always @(negedge clk) begin
        if (tdiv <= 1) ref_tick = 1'b1;
        else begin
            ref_tick = (tc == tdiv - 1);
            tc = (tc >= tdiv - 1) ? 0 : tc + 1;
        end
        if (hhalf == 0) hf_in = 1'b0;
        else if (hc >= hhalf - 1) begin hc = 0; hf_in = ~hf_in; end
        else hc++;
        if (lhalf == 0) lf_in = 1'b0;
        else if (lc >= lhalf - 1) begin lc = 0; lf_in = ~lf_in; end
        else lc++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic write_cfg(input logic [1:0] m, input logic [1:0] g);
        @(negedge clk) begin cfg_we = 1'b1; cfg_mode = m; cfg_gate = g; end
        @(negedge clk) cfg_we = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 6000) begin @(negedge clk); n++; end
        if (!done) chk({tag, " done timeout"}, 0, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count", int'(count), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 overflow", int'(overflow), 0);

        // R1: default configuration is fast-input frequency over 1 ms.
        tdiv = 8; hhalf = 2; lhalf = 8;
        pulse_start();
        wait_done("R1");
        chk("R1 default mode count", int'(count), 8);

        // R8: result held after done.
        repeat (50) @(negedge clk);
        chk("R8 done held", int'(done), 1);
        chk("R8 count held", int'(count), 8);

        // R3: start clears a finished result.
        pulse_start();
        chk("R3 count cleared", int'(count), 0);
        chk("R3 done cleared", int'(done), 0);
        wait_done("R3");

        // Vector table: R4 R5 R6 R7.
        for (int i = 0; i < 9; i++) begin
            tdiv = VECS[i].tdiv; hhalf = VECS[i].hhalf; lhalf = VECS[i].lhalf;
            write_cfg(VECS[i].mode, VECS[i].gate);
            pulse_start();
            wait_done($sformatf("R4/R5/R6/R7 vec %0d", i));
            chk($sformatf("R4/R5/R6/R7 vec %0d count", i), int'(count), VECS[i].exp_cnt);
            chk($sformatf("R4/R5/R6/R7 vec %0d overflow", i), int'(overflow), 0);
        end

        // R2: a write during a run is ignored now and later.
        tdiv = 8; hhalf = 2; lhalf = 8;
        write_cfg(2'd0, 2'd2);
        pulse_start();
        repeat (20) @(negedge clk);
        write_cfg(2'd1, 2'd0);
        wait_done("R2");
        chk("R2 write ignored in run", int'(count), 64);
        pulse_start();
        wait_done("R2b");
        chk("R2 config unchanged", int'(count), 64);

        // R3: restart mid-measurement.
        pulse_start();
        repeat (30) @(negedge clk);
        pulse_start();
        chk("R3 restart count", int'(count), 0);
        chk("R3 restart done", int'(done), 0);
        wait_done("R3b");
        chk("R3 restart result", int'(count), 64);

        // R9: saturation on the narrow instance.
        write_cfg(2'd0, 2'd3);
        pulse_start();
        wait_done("R9");
        chk("R9 wide count", int'(count), 128);
        chk("R9 narrow saturated", int'(count_n), 63);
        chk("R9 narrow overflow", int'(overflow_n), 1);

        // R10: period timeout with the slow input held low.
        tdiv = 1; lhalf = 0;
        write_cfg(2'd2, 2'd0);
        pulse_start();
        wait_done("R10");
        chk("R10 overflow", int'(overflow), 1);
        chk("R10 count", int'(count), 0);

        finish_run();
    end
endmodule